// File: doc/BRIEF.md
# Conjugate-Symmetric Spectrum Builder for a Real Inverse FFT

The block sits between the subcarrier mapper and an N-point inverse FFT in a multitone transmitter. It takes the N/2 complex subsymbols of one symbol, one per carrier, and stores them. It then streams out the full N-bin spectrum in natural bin order. The upper half of that spectrum is made of conjugated copies of the lower half, read in reverse. The transform of this vector is therefore a block of N purely real time samples.

Carrier 0 is packed. Its real part is the DC value and its imaginary part is the Nyquist value. Both leave the block as real-only bins, at index 0 and index N/2, and neither is copied. The input stream marks the first carrier of each symbol with a start flag. The output stream labels every bin with its index. While a symbol is being emitted the block accepts no input. Output backpressure stalls the emission.

Top module: `hermitian_mirror`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A sample accepted with in_sos=1 is stored as carrier 0 and opens a symbol. The following accepted samples are stored as carriers 1, 2, … in arrival order. Acceptance of carrier N/2−1 ends collection, and out_valid rises in the next cycle.
- R3: A sample accepted with in_sos=0 while no symbol is open is discarded and has no effect on the next emitted symbol.
- R4: A sample with in_sos=1 arriving while a symbol is still being collected discards the partial symbol and starts a new one at carrier 0.
- R5: in_ready stays 0 from the end of collection until the handshake of bin N−1. Inputs presented in that time have no effect.
- R6: Bins are emitted with out_idx running 0, 1, …, N−1. out_last is 1 only on bin N−1. After that handshake, out_valid is 0 and in_ready is 1 in the next cycle.
- R7: For 1 ≤ k ≤ N/2−1, bin k equals carrier k unchanged.
- R8: For N/2+1 ≤ k ≤ N−1, bin k is the complex conjugate of carrier N−k: the same real part and the negated imaginary part.
- R9: Bin 0 carries the real part of carrier 0 as its real part. Bin N/2 carries the imaginary part of carrier 0 as its real part. Both bins have imaginary part 0.
- R10: Negation saturates: an imaginary part of −2^(DW−1) becomes 2^(DW−1)−1 in the mirrored bin.
- R11: While out_valid is 1 and out_ready is 0, out_idx, out_re and out_im hold, and out_valid stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block accepts an input sample |
| in_sos | input | 1 | Sample is carrier 0 of a new symbol |
| in_re | input | DW | Real part of the subsymbol (signed) |
| in_im | input | DW | Imaginary part of the subsymbol (signed) |
| out_valid | output | 1 | Output bin present |
| out_ready | input | 1 | Downstream takes the bin |
| out_re | output | DW | Real part of the bin (signed) |
| out_im | output | DW | Imaginary part of the bin (signed) |
| out_idx | output | log2(N) | Bin index |
| out_last | output | 1 | Bin N−1 of the symbol |

## Verification
The mirror is tried with several symbols. One uses a ramp, whose reversed copies reveal any off-by-one in the read address. One uses arithmetic scrambled values, which separate the real and imaginary paths. One uses full-scale extremes, which expose wrong saturation of the negation and leaks of carrier 0's imaginary part into bin 0. Further runs cover stray samples before a start flag, a restart in the middle of collection, inputs offered during emission, and stalls on the output. These show whether resynchronisation, the input lockout and the hold under backpressure leave the emitted spectrum exactly equal to the expected one.

// File: rtl/hm_pkg.sv
// Package: shared types of the conjugate-symmetric spectrum builder.
package hm_pkg;
    // Phase of the block: gathering carriers, or streaming bins.
    typedef enum logic {
        HM_COLLECT = 1'b0,
        HM_EMIT    = 1'b1
    } hm_phase_e;
endpackage

// File: rtl/hm_seq.sv
// Sequencer: owns the phase, the write counter and the bin counter.
// Assumes HALF >= 2. It decides which accepted samples are written,
// and it advances the bin index on each output handshake.
module hm_seq
    import hm_pkg::*;
#(
    parameter int N_FFT = 512,
    localparam int HALF = N_FFT / 2,
    localparam int AW   = $clog2(HALF),
    localparam int IW   = $clog2(N_FFT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sos,
    output logic          in_ready,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    input  logic          out_ready,
    output logic          out_valid,
    output logic          out_last,
    output logic [IW-1:0] bin_idx
);
    hm_phase_e     phase;
    logic          opened;
    logic [AW-1:0] wr_cnt;
    logic          accept;
    logic          final_wr;
    logic          take;

    // Decode the handshakes and the write target of an accepted sample.
    always_comb begin
        in_ready  = (phase == HM_COLLECT);
        out_valid = (phase == HM_EMIT);
        accept    = in_valid && in_ready;
        wr_en     = accept && (in_sos || opened);
        wr_addr   = in_sos ? '0 : wr_cnt;
        final_wr  = wr_en && !in_sos && (wr_cnt == AW'(HALF - 1));
        out_last  = (bin_idx == IW'(N_FFT - 1));
        take      = out_valid && out_ready;
    end

    // Phase, write counter and bin counter updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= HM_COLLECT;
            opened  <= 1'b0;
            wr_cnt  <= '0;
            bin_idx <= '0;
        end else if (phase == HM_COLLECT) begin
            if (final_wr) begin
                phase   <= HM_EMIT;
                opened  <= 1'b0;
                wr_cnt  <= '0;
                bin_idx <= '0;
            end else if (wr_en) begin
                opened <= 1'b1;
                wr_cnt <= wr_addr + AW'(1);
            end
        end else if (take) begin
            bin_idx <= bin_idx + IW'(1);
            if (out_last) begin
                phase <= HM_COLLECT;
            end
        end
    end

    // R6: a non-final handshake steps the index by one
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> (out_valid && bin_idx == $past(bin_idx) + IW'(1)));

    // R6: after the final handshake the block returns to collection
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (!out_valid && in_ready));

    // R11: a stalled bin keeps its index and stays valid
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(bin_idx)));

    // R2: emission starts at bin 0
    a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (bin_idx == '0));
endmodule

// File: rtl/hm_store.sv
// Carrier store: HALF complex entries, one write port, one
// combinational read port. Contents are undefined until written.
module hm_store #(
    parameter int HALF = 256,
    parameter int DW   = 16,
    localparam int AW  = $clog2(HALF)
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic signed [DW-1:0] wr_re,
    input  logic signed [DW-1:0] wr_im,
    input  logic [AW-1:0]        rd_addr,
    output logic signed [DW-1:0] rd_re,
    output logic signed [DW-1:0] rd_im
);
    logic [2*DW-1:0] mem [HALF];

    // Write one carrier per accepted sample.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= {wr_re, wr_im};
        end
    end

    // Asynchronous read of the addressed carrier.
    always_comb begin
        {rd_re, rd_im} = mem[rd_addr];
    end
endmodule

// File: rtl/hm_map.sv
// Bin mapper: turns a bin index into a store address. It then shapes
// the bin: a straight copy in the lower half, a saturated conjugate in
// the upper half, and real-only DC/Nyquist values taken from carrier 0.
module hm_map #(
    parameter int N_FFT = 512,
    parameter int DW    = 16,
    localparam int HALF = N_FFT / 2,
    localparam int AW   = $clog2(HALF),
    localparam int IW   = $clog2(N_FFT)
) (
    input  logic [IW-1:0]        bin_idx,
    output logic [AW-1:0]        rd_addr,
    input  logic signed [DW-1:0] rd_re,
    input  logic signed [DW-1:0] rd_im,
    output logic signed [DW-1:0] bin_re,
    output logic signed [DW-1:0] bin_im
);
    localparam logic signed [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};

    logic          upper;
    logic          edge_bin;
    logic [IW-1:0] rev_idx;

    // Address: forward in the lower half, reflected in the upper half.
    always_comb begin
        upper    = bin_idx[IW-1];
        rev_idx  = IW'(0) - bin_idx;
        rd_addr  = upper ? rev_idx[AW-1:0] : bin_idx[AW-1:0];
        edge_bin = (bin_idx[AW-1:0] == '0);
    end

    // Value: edge bins real-only, upper half conjugated with saturation.
    always_comb begin
        if (edge_bin) begin
            bin_re = upper ? rd_im : rd_re;
            bin_im = '0;
        end else if (upper) begin
            bin_re = rd_re;
            bin_im = (rd_im == SMIN) ? SMAX : -rd_im;
        end else begin
            bin_re = rd_re;
            bin_im = rd_im;
        end
    end
endmodule

// File: rtl/hermitian_mirror.sv
// Top: collects N/2 carriers of one symbol, then streams the N-bin
// conjugate-symmetric spectrum for a real inverse FFT. Carrier 0 packs
// the DC value (real part) and the Nyquist value (imaginary part).
// Assumes N_FFT is a power of two and at least 4.
module hermitian_mirror #(
    parameter int N_FFT = 512,
    parameter int DW    = 16,
    localparam int IW   = $clog2(N_FFT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 in_sos,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic signed [DW-1:0] out_re,
    output logic signed [DW-1:0] out_im,
    output logic [IW-1:0]        out_idx,
    output logic                 out_last
);
    localparam int HALF = N_FFT / 2;
    localparam int AW   = $clog2(HALF);
    localparam logic signed [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

    logic                 wr_en;
    logic [AW-1:0]        wr_addr;
    logic [AW-1:0]        rd_addr;
    logic signed [DW-1:0] rd_re;
    logic signed [DW-1:0] rd_im;

    hm_seq #(.N_FFT(N_FFT)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sos   (in_sos),
        .in_ready (in_ready),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .out_ready(out_ready),
        .out_valid(out_valid),
        .out_last (out_last),
        .bin_idx  (out_idx)
    );

    hm_store #(.HALF(HALF), .DW(DW)) u_store (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_re  (in_re),
        .wr_im  (in_im),
        .rd_addr(rd_addr),
        .rd_re  (rd_re),
        .rd_im  (rd_im)
    );

    hm_map #(.N_FFT(N_FFT), .DW(DW)) u_map (
        .bin_idx(out_idx),
        .rd_addr(rd_addr),
        .rd_re  (rd_re),
        .rd_im  (rd_im),
        .bin_re (out_re),
        .bin_im (out_im)
    );

    // R9: DC and Nyquist bins leave with no imaginary part
    a_r9_real_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_idx == '0 || out_idx == IW'(HALF))) |-> (out_im == '0));

    // R10: a saturated negation never yields the most negative value
    a_r10_no_min: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_idx > IW'(HALF)) |-> (out_im != SMIN));

    // R11: a stalled bin keeps its value
    a_r11_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> ($stable(out_re) && $stable(out_im)));

    // R5: no input is taken while bins are being emitted
    a_r5_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(out_ready && out_last)) |=> !in_ready);
endmodule

// File: tb/hermitian_mirror_tb.sv
// Directed bench for the conjugate-symmetric spectrum builder.
module hermitian_mirror_tb;
    localparam int N    = 512;
    localparam int HALF = N / 2;
    localparam int DW   = 16;
    localparam int IW   = $clog2(N);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic                 in_sos = 1'b0;
    logic signed [DW-1:0] in_re = '0;
    logic signed [DW-1:0] in_im = '0;
    logic                 out_valid;
    logic                 out_ready = 1'b0;
    logic signed [DW-1:0] out_re;
    logic signed [DW-1:0] out_im;
    logic [IW-1:0]        out_idx;
    logic                 out_last;

    int n_chk = 0;
    int n_bad = 0;
    logic signed [DW-1:0] sym_re [HALF];
    logic signed [DW-1:0] sym_im [HALF];

    hermitian_mirror #(.N_FFT(N), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_sos(in_sos),
        .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_re(out_re), .out_im(out_im), .out_idx(out_idx), .out_last(out_last)
    );

    always #4 clk = ~clk;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        summary();
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected spectrum from the requirements R7, R8, R9, R10.
    function automatic logic signed [DW-1:0] neg_sat(input logic signed [DW-1:0] v);
        if (v == {1'b1, {(DW-1){1'b0}}}) return {1'b0, {(DW-1){1'b1}}};
        return -v;
    endfunction

    function automatic logic [2*DW-1:0] exp_bin(input int k);
        if (k == 0)          return {sym_re[0], 16'sd0};
        else if (k == HALF)  return {sym_im[0], 16'sd0};
        else if (k < HALF)   return {sym_re[k], sym_im[k]};
        else                 return {sym_re[N-k], neg_sat(sym_im[N-k])};
    endfunction

    // Offer one input sample and wait until it is taken.
    task automatic push(input logic sos, input logic signed [DW-1:0] re,
                        input logic signed [DW-1:0] im);
        @(negedge clk);
        in_valid = 1'b1; in_sos = sos; in_re = re; in_im = im;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic idle_in();
        @(negedge clk);
        in_valid = 1'b0; in_sos = 1'b0;
    endtask

    // Send the symbol held in sym_re/sym_im, carrier 0 flagged.
    task automatic send_symbol();
        for (int k = 0; k < HALF; k++) push(k == 0, sym_re[k], sym_im[k]);
    endtask

    // Receive all bins; optional stalls and junk inputs during emission.
    task automatic receive(input bit stall, input bit junk, input string req);
        int bad = 0;
        int first_bad = -1;
        logic [2*DW-1:0] got;
        bit lock_ok = 1'b1;
        if (junk) begin
            in_valid = 1'b1; in_sos = 1'b1; in_re = 16'sh1111; in_im = 16'sh2222;
        end
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            if (in_ready) lock_ok = 1'b0;
            if (stall && (k % 37 == 5)) begin
                logic [2*DW-1:0] cap;
                logic [IW-1:0]   cidx;
                out_ready = 1'b0;
                cap = {out_re, out_im}; cidx = out_idx;
                @(negedge clk);
                check(out_valid && out_idx == cidx && {out_re, out_im} == cap,
                      "R11", "stalled bin held", longint'(out_idx), longint'(cidx));
            end
            out_ready = 1'b1;
            got = {out_re, out_im};
            if (!out_valid || out_idx != IW'(k) || out_last != (k == N - 1) ||
                got != exp_bin(k)) begin
                bad++;
                if (first_bad < 0) begin
                    first_bad = k;
                    $display("FAIL %s bin %0d: actual idx %0d re %0d im %0d last %0b, expected re %0d im %0d",
                             req, k, out_idx, out_re, out_im, out_last,
                             $signed(exp_bin(k)[2*DW-1:DW]), $signed(exp_bin(k)[DW-1:0]));
                end
            end
            @(posedge clk);
        end
        n_chk++;
        if (bad != 0) n_bad++;
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b0; in_sos = 1'b0;
        check(!out_valid && in_ready, "R6", "return to collection",
              longint'({out_valid, in_ready}), 1);
        if (junk) check(lock_ok, "R5", "in_ready low during emission", lock_ok, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && in_ready, "R1", "reset state {out_valid,in_ready}",
              longint'({out_valid, in_ready}), 1);
    endtask

    task automatic t_ramp();
        for (int k = 0; k < HALF; k++) begin
            sym_re[k] = 16'(k + 1);
            sym_im[k] = 16'(1000 + k);
        end
        send_symbol();
        idle_in();
        check(out_valid && out_idx == '0, "R2", "valid after last carrier",
              longint'(out_valid), 1);
        receive(1'b0, 1'b0, "R7/R8");
    endtask

    task automatic t_scrambled(input int s);
        for (int k = 0; k < HALF; k++) begin
            sym_re[k] = 16'(k * 1237 + s * 331);
            sym_im[k] = 16'((k * 2917) ^ (s * 77 + 5));
        end
        send_symbol();
        idle_in();
        receive(1'b0, 1'b0, "R8");
    endtask

    task automatic t_extremes();
        for (int k = 0; k < HALF; k++) begin
            sym_re[k] = (k % 2) ? 16'sh7FFF : 16'sh8000;
            sym_im[k] = (k % 3 == 0) ? 16'sh8000 : ((k % 3 == 1) ? 16'sh7FFF : 16'sh8001);
        end
        send_symbol();
        idle_in();
        // R10: carrier 3 imag is most negative; mirrored bin N-3 must be max
        receive(1'b0, 1'b0, "R9/R10");
    endtask

    task automatic t_stray_first();
        push(1'b0, 16'sh5555, 16'sh5555);
        push(1'b0, 16'sh6666, 16'sh6666);
        for (int k = 0; k < HALF; k++) begin
            sym_re[k] = 16'(-k * 3);
            sym_im[k] = 16'(k * 5 - 7);
        end
        send_symbol();
        idle_in();
        receive(1'b0, 1'b0, "R3");
    endtask

    task automatic t_restart();
        for (int k = 0; k < 10; k++) push(k == 0, 16'sh3333, 16'sh4444);
        for (int k = 0; k < HALF; k++) begin
            sym_re[k] = 16'(k * 7 + 2);
            sym_im[k] = 16'(300 - k);
        end
        send_symbol();
        idle_in();
        receive(1'b0, 1'b0, "R4");
    endtask

    task automatic t_stall_and_junk();
        for (int k = 0; k < HALF; k++) begin
            sym_re[k] = 16'(k * 211);
            sym_im[k] = 16'(-(k * 97));
        end
        send_symbol();
        idle_in();
        receive(1'b1, 1'b1, "R11/R5");
        // R5: the junk symbol start must not have opened a symbol
        push(1'b0, 16'sh0AAA, 16'sh0BBB);
        idle_in();
        check(in_ready && !out_valid, "R3", "stray after emission ignored",
              longint'({in_ready, out_valid}), 2);
        t_scrambled(9);
    endtask

    initial begin
        t_reset();
        t_ramp();
        t_scrambled(1);
        t_scrambled(2);
        t_extremes();
        t_stray_first();
        t_restart();
        t_stall_and_junk();
        summary();
    end
endmodule